// File: doc/BRIEF.md
# Load/Store Lane Aligner

The block sits between the load/store stage of a 32-bit RISC core and a word-wide data memory. For each request it adds the base register to the sign-extended 16-bit displacement to form the effective address. It then issues one word-addressed memory transaction whose byte enables cover only the lanes the access touches. Stores are narrowed to their low byte or halfword, which is copied into every matching lane. When a load's data word comes back, the block picks the addressed byte or halfword out of it and widens it to 32 bits, filling with the sign bit or with zeros. A zero base gives absolute addressing and a zero displacement gives register-indirect addressing. Both come from the same adder.

Requests enter on a valid/ready port and are held in a single output register toward memory. The memory side is also valid/ready. While memory stalls, the presented transaction stays frozen and the request port stays not-ready. A request that is not naturally aligned never reaches memory. It raises a one-cycle misalignment pulse instead. Only one load may be in flight, and its data returns after memory has accepted it and before the next load is accepted. The widening uses the lane, size and sign of the last load that memory accepted.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `req_base + sign_extend(req_disp)` taken modulo 2^32, and `mem_addr` carries its bits 31:2.
- R2: `req_size` 00 means byte. A byte store drives `mem_be = 1 << ea[1:0]` and repeats `req_wdata[7:0]` in all four lanes. Little-endian: lane k is bits 8k+7:8k.
- R3: `req_size` 01 means halfword. A halfword store drives `mem_be` 0011 when `ea[1]` is 0 and 1100 when it is 1, and repeats `req_wdata[15:0]` in both halves.
- R4: `req_size` 10 (and also 11) means word, with `mem_be` 1111 and the data unchanged. `mem_we` is 1 for a store (`req_store`=1) and 0 for a load. A load presents the enables of the lanes it reads.
- R5: A halfword with `ea[0]`=1, or a word with `ea[1:0]`≠0, is misaligned. `misalign` is then high for exactly the one cycle after acceptance, no memory transaction is issued, and the load context is not changed.
- R6: A byte load returns lane `ea[1:0]` of `rsp_rdata`. It is sign-extended when `req_unsigned`=0 and zero-extended when `req_unsigned`=1.
- R7: A halfword load returns the half selected by `ea[1]`, extended the same way.
- R8: A word load returns `rsp_rdata` unchanged. `ld_valid` follows `rsp_valid` in the same cycle, and `ld_data` is combinational from it.
- R9: `req_ready` = `!mem_valid || mem_ready`. While `mem_valid && !mem_ready`, the memory outputs hold still and no request is taken.
- R10: After reset, `mem_valid` and `misalign` are 0 and `req_ready` is 1.
- R11: Load widening uses the lane, size and sign of the most recent load that memory accepted (`mem_valid && mem_ready && !mem_we`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store register value |
| mem_valid | output | 1 | Memory transaction present |
| mem_ready | input | 1 | Memory takes the transaction |
| mem_addr | output | 30 | Word address |
| mem_we | output | 1 | Write transaction |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| misalign | output | 1 | One-cycle misaligned-request pulse |
| rsp_valid | input | 1 | Load data word returned |
| rsp_rdata | input | 32 | Returned data word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Properties check on every cycle that a stalled transaction stays frozen, that a misalignment pulse never comes together with a memory transaction, that enables always have a legal lane count, that an accepted request yields either the right word address or a misalignment, and the state right after reset. The lane placement of data, the sign or zero fill of each narrow load, the address wrap, the treatment of size code 11, and the fact that a dropped misaligned load leaves the earlier load's context in force can only be shown by the bench's chosen vectors and response words.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_e;
endpackage

// File: rtl/lsa_addr_gen.sv
`timescale 1ns/1ps
module lsa_addr_gen #(
  parameter int AW     = 32,
  parameter int DISP_W = 16
) (
  input  logic [AW-1:0]     base,
  input  logic [DISP_W-1:0] disp,
  output logic [AW-1:0]     ea
);
  localparam int EXT_W = AW - DISP_W;
  logic [AW-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea = base + disp_ext;
endmodule

// File: rtl/lsa_store_lanes.sv
`timescale 1ns/1ps
module lsa_store_lanes
  import lsa_pkg::*;
#(
  parameter int DW = 32
) (
  input  size_e                         size,
  input  logic [$clog2(DW/8)-1:0]       off,
  input  logic [DW-1:0]                 data,
  output logic [DW/8-1:0]               be,
  output logic [DW-1:0]                 wdata,
  output logic                          mis
);
  localparam int NLANE = DW / 8;
  localparam int OFF_W = $clog2(NLANE);

  logic [DW-1:0]    rep_b, rep_h;
  logic [NLANE-1:0] be_b, be_h;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign rep_b[8*i +: 8] = data[7:0];
    assign rep_h[8*i +: 8] = data[8*(i%2) +: 8];
  end

  assign be_b = {{(NLANE-1){1'b0}}, 1'b1} << off;
  assign be_h = {{(NLANE-2){1'b0}}, 2'b11} << {off[OFF_W-1:1], 1'b0};

  always_comb begin
    unique case (size)
      SZ_BYTE: begin be = be_b; wdata = rep_b; mis = 1'b0; end
      SZ_HALF: begin be = be_h; wdata = rep_h; mis = off[0]; end
      default: begin be = '1;   wdata = data;  mis = (off != '0); end
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
`timescale 1ns/1ps
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DW = 32
) (
  input  size_e                   size,
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic                    uns,
  input  logic [DW-1:0]           rdata,
  output logic [DW-1:0]           result
);
  localparam int OFF_W = $clog2(DW/8);

  logic [DW-1:0] sh_b, sh_h;
  logic [7:0]    b;
  logic [15:0]   h;

  assign sh_b = rdata >> {off, 3'b000};
  assign sh_h = rdata >> {off[OFF_W-1:1], 4'b0000};
  assign b    = sh_b[7:0];
  assign h    = sh_h[15:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DW-8){~uns & b[7]}}, b};
      SZ_HALF: result = {{(DW-16){~uns & h[15]}}, h};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
`timescale 1ns/1ps
module lsu_lane_align
  import lsa_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DISP_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_store,
  input  logic [1:0]                    req_size,
  input  logic                          req_unsigned,
  input  logic [AW-1:0]                 req_base,
  input  logic [DISP_W-1:0]             req_disp,
  input  logic [DW-1:0]                 req_wdata,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic [AW-$clog2(DW/8)-1:0]    mem_addr,
  output logic                          mem_we,
  output logic [DW/8-1:0]               mem_be,
  output logic [DW-1:0]                 mem_wdata,
  output logic                          misalign,
  input  logic                          rsp_valid,
  input  logic [DW-1:0]                 rsp_rdata,
  output logic                          ld_valid,
  output logic [DW-1:0]                 ld_data
);
  localparam int NLANE = DW / 8;
  localparam int OFF_W = $clog2(NLANE);
  localparam int WA_W  = AW - OFF_W;

  size_e             size_in;
  logic [AW-1:0]     ea;
  logic [OFF_W-1:0]  off;
  logic [NLANE-1:0]  be_c;
  logic [DW-1:0]     wd_c;
  logic              mis_c;
  logic              accept;

  // output stage
  logic              v_q, we_q, mis_q;
  logic [WA_W-1:0]   addr_q;
  logic [NLANE-1:0]  be_q;
  logic [DW-1:0]     wd_q;
  logic [OFF_W-1:0]  off_q;
  size_e             size_q;
  logic              uns_q;

  // context of last load accepted by memory
  logic [OFF_W-1:0]  ctx_off;
  size_e             ctx_size;
  logic              ctx_uns;

  assign size_in = size_e'(req_size);

  lsa_addr_gen #(.AW(AW), .DISP_W(DISP_W)) u_addr (
    .base (req_base),
    .disp (req_disp),
    .ea   (ea)
  );

  assign off = ea[OFF_W-1:0];

  lsa_store_lanes #(.DW(DW)) u_lanes (
    .size  (size_in),
    .off   (off),
    .data  (req_wdata),
    .be    (be_c),
    .wdata (wd_c),
    .mis   (mis_c)
  );

  assign req_ready = !v_q || mem_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      mis_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      off_q  <= '0;
      size_q <= SZ_WORD;
      uns_q  <= 1'b0;
    end else begin
      mis_q <= accept && mis_c;
      if (req_ready) begin
        v_q <= accept && !mis_c;
        if (accept && !mis_c) begin
          we_q   <= req_store;
          addr_q <= ea[AW-1:OFF_W];
          be_q   <= be_c;
          wd_q   <= req_store ? wd_c : '0;
          off_q  <= off;
          size_q <= size_in;
          uns_q  <= req_unsigned;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_off  <= '0;
      ctx_size <= SZ_WORD;
      ctx_uns  <= 1'b0;
    end else if (v_q && mem_ready && !we_q) begin
      ctx_off  <= off_q;
      ctx_size <= size_q;
      ctx_uns  <= uns_q;
    end
  end

  assign mem_valid = v_q;
  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_be    = be_q;
  assign mem_wdata = wd_q;
  assign misalign  = mis_q;

  lsa_load_extract #(.DW(DW)) u_extract (
    .size   (ctx_size),
    .off    (ctx_off),
    .uns    (ctx_uns),
    .rdata  (rsp_rdata),
    .result (ld_data)
  );

  assign ld_valid = rsp_valid;
endmodule

// File: rtl/lsa_checker.sv
`timescale 1ns/1ps
module lsa_checker #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DISP_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [1:0]                 req_size,
  input logic [AW-1:0]              req_base,
  input logic [DISP_W-1:0]          req_disp,
  input logic                       mem_valid,
  input logic                       mem_ready,
  input logic [AW-$clog2(DW/8)-1:0] mem_addr,
  input logic                       mem_we,
  input logic [DW/8-1:0]            mem_be,
  input logic [DW-1:0]              mem_wdata,
  input logic                       misalign
);
  localparam int NLANE = DW / 8;
  localparam int OFF_W = $clog2(NLANE);

  logic [AW-1:0] ea_sum;
  assign ea_sum = req_base + {{(AW-DISP_W){req_disp[DISP_W-1]}}, req_disp};

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  mis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_valid);

  // R5
  word_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size[1] && (ea_sum[OFF_W-1:0] != '0)) |=> misalign);

  // R2 R3 R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                   || $countones(mem_be) == NLANE));

  // R1
  ea_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (misalign || (mem_valid && mem_addr == $past(ea_sum[AW-1:OFF_W]))));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_valid && !misalign));
endmodule

bind lsu_lane_align lsa_checker #(.AW(AW), .DW(DW), .DISP_W(DISP_W)) u_lsa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .req_base  (req_base),
  .req_disp  (req_disp),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .misalign  (misalign)
);

// File: tb/test_lsu_lane_align.sv
`timescale 1ns/1ps
module test_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [29:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata), .misalign(misalign),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        un;
    logic [31:0] base;
    logic [15:0] disp;
    logic [31:0] dat;
    logic [29:0] ew;
    logic [3:0]  be;
    logic [31:0] res;
    logic        mis;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h0000_1000, 16'h0003, 32'h1234_56AB, 30'h400,       4'b1000, 32'hABAB_ABAB, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_2000, 16'hFFFE, 32'hDEAD_BEEF, 30'h7FF,       4'b1100, 32'hBEEF_BEEF, 1'b0},
    '{1'b1, 2'd2, 1'b0, 32'h0000_0000, 16'h0040, 32'hCAFE_F00D, 30'h10,        4'b1111, 32'hCAFE_F00D, 1'b0},
    '{1'b1, 2'd2, 1'b0, 32'h0000_0100, 16'h0002, 32'h0000_0001, 30'h0,         4'b0000, 32'h0,         1'b1},
    '{1'b1, 2'd1, 1'b0, 32'h0000_0101, 16'h0000, 32'h0000_0001, 30'h0,         4'b0000, 32'h0,         1'b1},
    '{1'b0, 2'd0, 1'b0, 32'h0000_3000, 16'h0001, 32'h1122_9344, 30'hC00,       4'b0010, 32'hFFFF_FF93, 1'b0},
    '{1'b0, 2'd0, 1'b1, 32'h0000_3000, 16'h0001, 32'h1122_9344, 30'hC00,       4'b0010, 32'h0000_0093, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h8000_0000, 16'h7FFE, 32'hF00D_1234, 30'h2000_1FFF, 4'b1100, 32'hFFFF_F00D, 1'b0},
    '{1'b0, 2'd1, 1'b1, 32'h0000_0010, 16'h0000, 32'hAAAA_8001, 30'h4,         4'b0011, 32'h0000_8001, 1'b0},
    '{1'b0, 2'd2, 1'b0, 32'hFFFF_FFFC, 16'h0008, 32'h0123_4567, 30'h1,         4'b1111, 32'h0123_4567, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0003, 16'h0000, 32'h7F00_0000, 30'h0,         4'b1000, 32'h0000_007F, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0003, 16'h0000, 32'h0000_0000, 30'h0,         4'b0000, 32'h0,         1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic st, input logic [1:0] sz);
    if (st) return (sz == 2'd0) ? "R2 byte store" : (sz == 2'd1) ? "R3 half store" : "R4 word store";
    return (sz == 2'd0) ? "R6 byte load" : (sz == 2'd1) ? "R7 half load" : "R8 word load";
  endfunction

  task automatic drive_req(input logic st, input logic [1:0] sz, input logic un,
                           input logic [31:0] base, input logic [15:0] disp, input logic [31:0] d);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = un;
    req_base = base; req_disp = disp; req_wdata = d;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R10 misalign", {31'b0, misalign}, 32'd0);
    chk("R10 req_ready", {31'b0, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_req(VT[v].st, VT[v].sz, VT[v].un, VT[v].base, VT[v].disp, VT[v].dat);
      @(negedge clk);
      req_valid = 1'b0;
      if (VT[v].mis) begin
        chk("R5 misalign pulse", {31'b0, misalign}, 32'd1);
        chk("R5 no transaction", {31'b0, mem_valid}, 32'd0);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'b0, misalign}, 32'd0);
      end else begin
        chk("R1 word address", {2'b0, mem_addr}, {2'b0, VT[v].ew});
        chk(tag_of(VT[v].st, VT[v].sz), {28'b0, mem_be}, {28'b0, VT[v].be});
        chk("R4 write flag", {31'b0, mem_we}, {31'b0, VT[v].st});
        if (VT[v].st) begin
          chk(tag_of(VT[v].st, VT[v].sz), mem_wdata, VT[v].res);
        end else begin
          @(negedge clk);
          rsp_valid = 1'b1;
          rsp_rdata = VT[v].dat;
          #2;
          chk(tag_of(VT[v].st, VT[v].sz), ld_data, VT[v].res);
          chk("R8 ld_valid", {31'b0, ld_valid}, 32'd1);
          rsp_valid = 1'b0;
        end
      end
    end

    // R11: the dropped misaligned load leaves the byte-lane-3 signed context in force
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_rdata = 32'h8000_0000;
    #2;
    chk("R11 context kept", ld_data, 32'hFFFF_FF80);
    rsp_valid = 1'b0;

    // R9: back-pressure from memory
    @(negedge clk);
    mem_ready = 1'b0;
    drive_req(1'b1, 2'd2, 1'b0, 32'h0000_0200, 16'h0000, 32'h0000_0055);
    @(negedge clk);
    drive_req(1'b1, 2'd0, 1'b0, 32'h0000_0300, 16'h0000, 32'h0000_00A5);
    chk("R9 held valid", {31'b0, mem_valid}, 32'd1);
    chk("R9 not ready", {31'b0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 address frozen", {2'b0, mem_addr}, 32'h80);
    chk("R9 data frozen", mem_wdata, 32'h0000_0055);
    chk("R9 still not ready", {31'b0, req_ready}, 32'd0);
    mem_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next request address", {2'b0, mem_addr}, 32'hC0);
    chk("R9 next request lanes", {28'b0, mem_be}, 32'b0001);
    chk("R2 replicated byte", mem_wdata, 32'hA5A5_A5A5);

    // R4: size code 11 behaves as word
    @(negedge clk);
    drive_req(1'b1, 2'd3, 1'b0, 32'h0000_0044, 16'h0000, 32'h1234_5678);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 code 11 lanes", {28'b0, mem_be}, 32'b1111);
    chk("R4 code 11 data", mem_wdata, 32'h1234_5678);
    chk("R4 code 11 address", {2'b0, mem_addr}, 32'h11);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule